// File: doc/BRIEF.md
# Vector Add Element Sequencer with Data-Dependent Truncation

This block runs one vector integer add, one element per clock, in strict element order from element 0 upward. A start pulse latches the vector length, the element width code, a 5-bit mode word, the Rc flag and a predicate mask. Each element adds the matching lanes of two flat operand buses, which are held stable for the whole run. For every element the block can issue a result write and a 4-bit condition-field write. When the run ends it pulses a done flag together with the final vector length.

The mode word picks one of four behaviours. Plain mode forms the wrapping sum, and can optionally write zeros for masked-off elements. Saturating mode clamps each sum to the unsigned or signed range of the element width. Fail-on-first mode tests each element and cuts the vector at the first element that fails. Predicate-by-result mode uses the same test to suppress single result writes. The fail-on-first test may shorten the vector all the way to zero.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `done_o`, `wr_en_o` and `cr_we_o` are low, and they stay low until a start is accepted.
- R2: Elements are handled one per cycle in ascending order from 0. A start sampled at clock edge e processes element k at edge e+k+1, and that element's writes are visible after that edge. Element k writes to `wr_idx_o = k`.
- R3: The element width code `elw_i` selects the width: 00 is 64 bits, 01 is 8 bits, 10 is 16 bits and 11 is 32 bits. Each operand is the low bits of its 64-bit lane at that width. A result is the sum modulo 2^width, zero-extended to 64 bits.
- R4: Family `mode_i[4:3]` = 10 with `mode_i[2]` = 0 is unsigned saturation: a sum above 2^width−1 is written as 2^width−1.
- R5: Family 10 with `mode_i[2]` = 1 is signed saturation: a sum is clamped to the range −2^(width−1) to 2^(width−1)−1 of the element width, written in two's complement.
- R6: When `rc_i` = 1, the condition-field write for element k goes to index 8+k. The field is {LT,GT,EQ,SO} in bits 3..0. LT, GT and EQ come from a signed compare of the element result against zero. SO is always 0.
- R7: Element k is enabled when `pred_i[k]` = 1. A disabled element produces no write. The exception is family 00 with `mode_i[0]` = 1: there the element writes a zero result and no condition field.
- R8: Family 01 is fail-on-first. At the first enabled element k that fails the test, nothing is written for element k, and later elements are not processed. Done rises at that edge with a final length of k.
- R9: In fail-on-first, a failure at element 0 ends the run with a final length of 0.
- R10: The test works as follows. With `rc_i` = 1, it reads the bit of the condition field chosen by `mode_i[1:0]` (0 = LT, 1 = GT, 2 = EQ, 3 = SO). With `rc_i` = 0, it reads "result is nonzero". The element passes when that value XOR `mode_i[2]` is 1.
- R11: Family 11 is predicate-by-result. An enabled element that fails the test writes no result, but it still writes its condition field when `rc_i` = 1.
- R12: The vector length is `vl_i` clamped to MAXVL. If it is 0, done is high after the start edge, with a final length of 0 and no writes.
- R13: Done is high for one cycle. It rises together with the last element's writes and the final length. A start while a run is in progress is ignored. Family 00 with `mode_i[2]` = 1 behaves exactly like family 00 with `mode_i[2]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; honoured only when idle |
| vl_i | input | VLW (4) | Requested vector length |
| elw_i | input | 2 | Element width code |
| mode_i | input | 5 | Mode word: [4:3] family, [2] inv/signed, [1:0] bit select / zeroing |
| rc_i | input | 1 | Write condition fields and test them |
| pred_i | input | MAXVL (8) | Element enable mask |
| src_a_i | input | MAXVL*XLEN (512) | First operand lanes, lane k at [k*64 +: 64] |
| src_b_i | input | MAXVL*XLEN (512) | Second operand lanes |
| wr_en_o | output | 1 | Result write strobe |
| wr_idx_o | output | IW (3) | Element index of the result write |
| wr_data_o | output | XLEN (64) | Result value |
| cr_we_o | output | 1 | Condition-field write strobe |
| cr_idx_o | output | CRW (7) | Condition register index (8 + element) |
| cr_data_o | output | 4 | {LT,GT,EQ,SO} |
| done_o | output | 1 | One-cycle end-of-run pulse |
| vl_o | output | VLW (4) | Final vector length, valid with done |

## Verification
The sweep covers every family, every inv/signed bit, every bit select, both Rc values and all four element widths. Runs use full masks and random masks, with lengths from 0 up to beyond MAXVL. Operand lanes are drawn from zero, all-ones, signed maximum and minimum patterns, byte-replicated 0x7F and 0x80 patterns, and random values. This mix makes unsigned carry, signed overflow and zero results each occur at every width. Random masks separate skipped elements from zeroed elements. Pairing Rc with the bit select and inv separates the condition-bit test from the nonzero test, and truncation at element 0 from truncation later in the vector. Some runs pulse start mid-run with a different configuration, to show that a run in progress cannot be restarted.

// File: rtl/ves_pkg.sv
package ves_pkg;

    typedef enum logic [1:0] {
        FAM_NORMAL = 2'b00,
        FAM_FFIRST = 2'b01,
        FAM_SAT    = 2'b10,
        FAM_PRED   = 2'b11
    } fam_e;

    // width in bits selected by the element width code
    function automatic int elw_bits(input logic [1:0] code, input int xlen);
        case (code)
            2'b01:   return 8;
            2'b10:   return 16;
            2'b11:   return 32;
            default: return xlen;
        endcase
    endfunction

endpackage

// File: rtl/ves_alu.sv
module ves_alu #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [1:0]      elw_i,
    input  logic            sat_en_i,
    input  logic            sat_signed_i,
    output logic [XLEN-1:0] res_o,
    output logic [3:0]      cr_o
);
    localparam int SW = XLEN + 1;

    int              w;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] am;
    logic [XLEN-1:0] bm;
    logic [XLEN:0]   sum;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] smax;
    logic [XLEN-1:0] smin;
    logic            carry;
    logic            sa;
    logic            sb;
    logic            sr;
    logic            lt;
    logic            eq;

    always_comb begin
        w     = ves_pkg::elw_bits(elw_i, XLEN);
        mask  = (w >= XLEN) ? '1 : ((XLEN'(1) << w) - XLEN'(1));
        am    = a_i & mask;
        bm    = b_i & mask;
        sum   = {1'b0, am} + {1'b0, bm};
        raw   = sum[XLEN-1:0] & mask;
        carry = |((sum >> w) & SW'(1));
        sa    = |((am  >> (w - 1)) & XLEN'(1));
        sb    = |((bm  >> (w - 1)) & XLEN'(1));
        sr    = |((raw >> (w - 1)) & XLEN'(1));
        smax  = mask >> 1;
        smin  = mask & ~smax;

        res_o = raw;
        if (sat_en_i) begin
            if (sat_signed_i) begin
                if ((sa == sb) && (sr != sa)) res_o = sa ? smin : smax;
            end else if (carry) begin
                res_o = mask;
            end
        end

        lt   = |((res_o >> (w - 1)) & XLEN'(1));
        eq   = (res_o == '0);
        cr_o = {lt, !lt && !eq, eq, 1'b0};
    end

endmodule

// File: rtl/ves_cond.sv
module ves_cond (
    input  logic [3:0] cr_i,
    input  logic       res_nz_i,
    input  logic       rc_i,
    input  logic       inv_i,
    input  logic [1:0] sel_i,
    output logic       pass_o
);
    logic bit_v;

    always_comb begin
        case (sel_i)
            2'd0:    bit_v = cr_i[3];
            2'd1:    bit_v = cr_i[2];
            2'd2:    bit_v = cr_i[1];
            default: bit_v = cr_i[0];
        endcase
        pass_o = (rc_i ? bit_v : res_nz_i) ^ inv_i;
    end

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
    parameter int XLEN    = 64,
    parameter int MAXVL   = 8,
    parameter int CRW     = 7,
    parameter int CR_BASE = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic [$clog2(MAXVL+1)-1:0] vl_i,
    input  logic [1:0]             elw_i,
    input  logic [4:0]             mode_i,
    input  logic                   rc_i,
    input  logic [MAXVL-1:0]       pred_i,
    input  logic [MAXVL*XLEN-1:0]  src_a_i,
    input  logic [MAXVL*XLEN-1:0]  src_b_i,
    output logic                   wr_en_o,
    output logic [$clog2(MAXVL)-1:0] wr_idx_o,
    output logic [XLEN-1:0]        wr_data_o,
    output logic                   cr_we_o,
    output logic [CRW-1:0]         cr_idx_o,
    output logic [3:0]             cr_data_o,
    output logic                   done_o,
    output logic [$clog2(MAXVL+1)-1:0] vl_o
);
    import ves_pkg::*;

    localparam int VLW = $clog2(MAXVL + 1);
    localparam int IW  = $clog2(MAXVL);

    typedef struct packed {
        logic             busy;
        logic [IW-1:0]    idx;
        logic [VLW-1:0]   vl;
        logic [1:0]       elw;
        logic [4:0]       mode;
        logic             rc;
        logic [MAXVL-1:0] pred;
        logic             done;
        logic [VLW-1:0]   vl_out;
        logic             wr_en;
        logic [IW-1:0]    wr_idx;
        logic [XLEN-1:0]  wr_data;
        logic             cr_we;
        logic [CRW-1:0]   cr_idx;
        logic [3:0]       cr_data;
    } state_t;

    state_t d, q;

    logic [XLEN-1:0] alu_res;
    logic [3:0]      alu_cr;
    logic            pass;
    fam_e            fam;

    assign fam = fam_e'(q.mode[4:3]);

    ves_alu #(.XLEN(XLEN)) u_alu (
        .a_i          (src_a_i[q.idx*XLEN +: XLEN]),
        .b_i          (src_b_i[q.idx*XLEN +: XLEN]),
        .elw_i        (q.elw),
        .sat_en_i     (fam == FAM_SAT),
        .sat_signed_i (q.mode[2]),
        .res_o        (alu_res),
        .cr_o         (alu_cr)
    );

    ves_cond u_cond (
        .cr_i     (alu_cr),
        .res_nz_i (|alu_res),
        .rc_i     (q.rc),
        .inv_i    (q.mode[2]),
        .sel_i    (q.mode[1:0]),
        .pass_o   (pass)
    );

    logic [VLW-1:0]  vl_eff;
    logic            last;
    logic            en;
    logic            stop;
    logic            do_wr;
    logic            do_cr;
    logic [XLEN-1:0] wdata;

    always_comb begin
        vl_eff = (vl_i > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_i;
        last   = (VLW'(q.idx) + VLW'(1)) == q.vl;
        en     = q.pred[q.idx];
        stop   = 1'b0;
        do_wr  = 1'b0;
        do_cr  = 1'b0;
        wdata  = alu_res;

        d       = q;
        d.done  = 1'b0;
        d.wr_en = 1'b0;
        d.cr_we = 1'b0;

        if (!q.busy) begin
            if (start_i) begin
                d.elw  = elw_i;
                d.mode = mode_i;
                d.rc   = rc_i;
                d.pred = pred_i;
                d.vl   = vl_eff;
                d.idx  = '0;
                if (vl_eff == '0) begin
                    d.done   = 1'b1;
                    d.vl_out = '0;
                end else begin
                    d.busy = 1'b1;
                end
            end
        end else begin
            if (!en) begin
                if (fam == FAM_NORMAL && q.mode[0]) begin
                    do_wr = 1'b1;
                    wdata = '0;
                end
            end else begin
                case (fam)
                    FAM_FFIRST: begin
                        stop  = !pass;
                        do_wr = pass;
                        do_cr = pass && q.rc;
                    end
                    FAM_PRED: begin
                        do_wr = pass;
                        do_cr = q.rc;
                    end
                    default: begin
                        do_wr = 1'b1;
                        do_cr = q.rc;
                    end
                endcase
            end

            d.wr_en   = do_wr;
            d.wr_idx  = q.idx;
            d.wr_data = wdata;
            d.cr_we   = do_cr;
            d.cr_idx  = CRW'(CR_BASE) + CRW'(q.idx);
            d.cr_data = alu_cr;

            if (stop) begin
                d.busy   = 1'b0;
                d.done   = 1'b1;
                d.vl_out = VLW'(q.idx);
            end else if (last) begin
                d.busy   = 1'b0;
                d.done   = 1'b1;
                d.vl_out = q.vl;
            end else begin
                d.idx = q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign wr_en_o   = q.wr_en;
    assign wr_idx_o  = q.wr_idx;
    assign wr_data_o = q.wr_data;
    assign cr_we_o   = q.cr_we;
    assign cr_idx_o  = q.cr_idx;
    assign cr_data_o = q.cr_data;
    assign done_o    = q.done;
    assign vl_o      = q.vl_out;

    // done lasts a single cycle
    p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // zero length start finishes at once with nothing written
    p_zero_len_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!q.busy && start_i && vl_i == '0) |=> (done_o && vl_o == '0 && !wr_en_o && !cr_we_o));

    // condition fields land in the vector window with SO clear
    p_cr_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_we_o |-> (cr_idx_o >= CRW'(CR_BASE) && cr_idx_o < CRW'(CR_BASE + MAXVL) && !cr_data_o[0]));

    // results never carry bits above the element width
    p_res_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && q.elw != 2'b00) |-> ((wr_data_o >> elw_bits(q.elw, XLEN)) == '0));

    // back-to-back writes are for consecutive elements
    p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o == $past(wr_idx_o) + IW'(1)));

    // a truncated length never exceeds the vector capacity
    p_vl_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (vl_o <= VLW'(MAXVL)));

    // a condition field without a result only in predicate-by-result mode
    p_cr_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cr_we_o && !wr_en_o) |-> (q.mode[4:3] == FAM_PRED));

endmodule

// File: tb/vec_elem_seq_bench.sv
`timescale 1ns/1ps
module vec_elem_seq_bench;
    localparam int XLEN  = 64;
    localparam int MAXVL = 8;
    localparam int VLW   = 4;
    localparam int IW    = 3;
    localparam int CRW   = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VLW-1:0] vl = '0;
    logic [1:0] elw = '0;
    logic [4:0] mode = '0;
    logic rc = 1'b0;
    logic [MAXVL-1:0] pred = '0;
    logic [MAXVL*XLEN-1:0] src_a = '0;
    logic [MAXVL*XLEN-1:0] src_b = '0;
    logic wr_en, cr_we, done;
    logic [IW-1:0] wr_idx;
    logic [XLEN-1:0] wr_data;
    logic [CRW-1:0] cr_idx;
    logic [3:0] cr_data;
    logic [VLW-1:0] vl_out;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    vec_elem_seq u_vec_elem_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl), .elw_i(elw),
        .mode_i(mode), .rc_i(rc), .pred_i(pred), .src_a_i(src_a), .src_b_i(src_b),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .cr_we_o(cr_we),
        .cr_idx_o(cr_idx), .cr_data_o(cr_data), .done_o(done), .vl_o(vl_out)
    );

    task automatic check(input logic ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] c);
        case (c)
            2'b01: return 8;
            2'b10: return 16;
            2'b11: return 32;
            default: return 64;
        endcase
    endfunction

    // kind: 0 wrap, 1 unsigned clamp, 2 signed clamp
    function automatic logic [63:0] model_add(input logic [63:0] a, input logic [63:0] b,
                                              input logic [1:0] c, input int kind);
        int w = wbits(c);
        logic signed [67:0] one = 68'sd1;
        logic signed [67:0] m = (one <<< w) - one;
        logic signed [67:0] av = $signed({4'b0, a}) & m;
        logic signed [67:0] bv = $signed({4'b0, b}) & m;
        logic signed [67:0] s;
        logic signed [67:0] hi = (one <<< (w - 1)) - one;
        logic signed [67:0] lo = -(one <<< (w - 1));
        if (kind == 2) begin
            if (a[w-1]) av = av - (one <<< w);
            if (b[w-1]) bv = bv - (one <<< w);
        end
        s = av + bv;
        if (kind == 1 && s > m) s = m;
        if (kind == 2) begin
            if (s > hi) s = hi;
            if (s < lo) s = lo;
        end
        s = s & m;
        return s[63:0];
    endfunction

    function automatic logic [3:0] model_cr(input logic [63:0] r, input logic [1:0] c);
        int w = wbits(c);
        logic neg = r[w-1];
        logic z = (r == 64'd0);
        return {neg, !neg && !z, z, 1'b0};
    endfunction

    function automatic logic [63:0] pick_val();
        case ($urandom % 8)
            0: return 64'd0;
            1: return '1;
            2: return 64'h7FFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h8080_8080_8080_8080;
            5: return 64'h7F7F_7F7F_7F7F_7F7F;
            6: return 64'd1;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    task automatic run(input logic [VLW-1:0] v, input logic [1:0] e, input logic [4:0] md,
                       input logic r, input logic [MAXVL-1:0] p, input logic restart);
        int veff = (v > MAXVL) ? MAXVL : int'(v);
        logic [1:0] fam = md[4:3];
        @(negedge clk);
        vl = v; elw = e; mode = md; rc = r; pred = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (veff == 0) begin
            // R12: empty run completes after the start edge with no writes
            check(done && vl_out == 0 && !wr_en && !cr_we, "R12",
                  96'({done, vl_out, wr_en, cr_we}), 96'({1'b1, 4'd0, 1'b0, 1'b0}));
        end else begin
            check(!done && !wr_en && !cr_we, "R2", 96'({done, wr_en, cr_we}), 96'd0);
            for (int k = 0; k < veff; k++) begin
                logic [63:0] a = src_a[k*XLEN +: XLEN];
                logic [63:0] b = src_b[k*XLEN +: XLEN];
                int kind = (fam == 2'b10) ? (md[2] ? 2 : 1) : 0;
                logic [63:0] res = model_add(a, b, e, kind);
                logic [3:0] crv = model_cr(res, e);
                logic tbit = r ? crv[3 - md[1:0]] : (res != 0);
                logic ok_t = tbit ^ md[2];
                logic xw = 1'b0, xc = 1'b0, xstop = 1'b0, xdone;
                logic [63:0] xdata = res;
                logic [VLW-1:0] xvl;
                string tag;
                if (restart && k == 1) begin
                    // R13: a start during a run must be ignored
                    start = 1'b1; vl = 4'd0; mode = ~md; elw = ~e; pred = ~p;
                end
                if (!p[k]) begin
                    if (fam == 2'b00 && md[0]) begin xw = 1'b1; xdata = 64'd0; end
                    tag = "R7";
                end else begin
                    case (fam)
                        2'b01: begin xstop = !ok_t; xw = ok_t; xc = ok_t && r; tag = "R8"; end
                        2'b11: begin xw = ok_t; xc = r; tag = "R11"; end
                        2'b10: begin xw = 1'b1; xc = r; tag = md[2] ? "R5" : "R4"; end
                        default: begin xw = 1'b1; xc = r; tag = "R3"; end
                    endcase
                end
                xdone = xstop || (k == veff - 1);
                xvl = xstop ? VLW'(k) : VLW'(veff);
                @(negedge clk);
                start = 1'b0;
                // R2: result write for element k, in order
                if (xw)
                    check(wr_en && wr_idx == IW'(k) && wr_data == xdata, tag,
                          96'({wr_en, wr_idx, wr_data}), 96'({1'b1, IW'(k), xdata}));
                else
                    check(!wr_en, tag, 96'(wr_en), 96'd0);
                // R6 field contents, R10 test outcome seen through the strobes
                if (xc)
                    check(cr_we && cr_idx == CRW'(8 + k) && cr_data == crv, "R6",
                          96'({cr_we, cr_idx, cr_data}), 96'({1'b1, CRW'(8 + k), crv}));
                else
                    check(!cr_we, "R10", 96'(cr_we), 96'd0);
                check(done == xdone && (!xdone || vl_out == xvl),
                      (xstop && k == 0) ? "R9" : (xstop ? "R8" : "R13"),
                      96'({done, vl_out}), 96'({xdone, xvl}));
                if (xstop) break;
            end
        end
        @(negedge clk);
        // R13: done is a pulse and nothing follows the run
        check(!done && !wr_en && !cr_we, "R13", 96'({done, wr_en, cr_we}), 96'd0);
    endtask

    task automatic fill_operands();
        for (int k = 0; k < MAXVL; k++) begin
            src_a[k*XLEN +: XLEN] = pick_val();
            src_b[k*XLEN +: XLEN] = pick_val();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(!done && !wr_en && !cr_we, "R1", 96'({done, wr_en, cr_we}), 96'd0);

        // R9: every element sums to zero, nonzero test fails at element 0
        src_a = '0; src_b = '0;
        run(4'd8, 2'b00, 5'b01000, 1'b0, '1, 1'b0);
        // R12: requested length above capacity is clamped
        fill_operands();
        run(4'd15, 2'b01, 5'b00000, 1'b1, '1, 1'b0);
        // R13: reduce encoding acts as plain mode
        run(4'd8, 2'b10, 5'b00101, 1'b1, 8'hA5, 1'b0);

        for (int f = 0; f < 4; f++)
            for (int b2 = 0; b2 < 2; b2++)
                for (int s = 0; s < 4; s++)
                    for (int r = 0; r < 2; r++)
                        for (int e = 0; e < 4; e++)
                            for (int t = 0; t < 4; t++) begin
                                logic [4:0] md = {2'(f), 1'(b2), 2'(s)};
                                logic [VLW-1:0] v = (t == 0) ? 4'd8 : VLW'($urandom_range(0, 10));
                                logic [MAXVL-1:0] p = (t == 0) ? '1 : MAXVL'($urandom);
                                fill_operands();
                                run(v, 2'(e), md, 1'(r), p, t == 3);
                            end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 150000);
        vectors++;
        miscompares++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule